// File: doc/BRIEF.md
# Truncated-Coefficient Block Reader with Zero Fill

This block sits between a pipelined SRAM that holds a compressed image and an inverse-transform stage. Each stored image is a sequence of 8x8 coefficient blocks from which only the low-frequency top-left KxK square was kept. The words for one image sit at consecutive addresses. On a read request the block walks every one of the 64 positions of every block in row-major order. It reads a memory word only at the kept positions and rebuilds the full 64-value stream, putting zeros where coefficients were dropped.

The SRAM returns data two cycles after it receives the address. The reader issues each address ahead of time and delays its own position bookkeeping to match. The inverse transform has a fixed latency (93 cycles by default). The reader starts a timer on the first coefficient it presents. It then opens an output gate over the reconstructed pixel input for exactly 64 times the block count cycles. A read-frame flag stays high from the request until the last gated pixel. This flag marks that the block owns the shared memory. While the block reads, its write-enable output stays low.

Top module: `trc_reader`

## Requirements
- R1: A request `rd_req` sampled high at a clock edge while `read_frame` is low and `num_blocks` is non-zero raises `read_frame` in the next cycle. `read_frame` stays high through the last cycle of `pix_valid` and is low in the cycle after. A request sampled while `read_frame` is high, or with `num_blocks` equal to 0, has no effect.
- R2: The kept size K is taken from the 4-bit `comp_lvl`. Values 1 to 8 are used as they are. Values 0 and 9 to 15 are treated as 8, which means no truncation.
- R3: Starting in the cycle after an accepted request, one block position is issued per cycle: 64 positions per block, row-major within a block (column fastest), blocks in order, with no gaps. `mem_cen` is high in the cycle a position is issued only if its row < K and its column < K. `mem_cen` is low at every other position and whenever no position is issued.
- R4: The first position with `mem_cen` high presents `start_addr` on `mem_addr`. Each later position with `mem_cen` high presents the previous address plus one, continuing across block boundaries.
- R5: The SRAM word for an address issued in cycle t is taken from `mem_rdata` in cycle t+2. The coefficient for the position issued in cycle t appears on `coef_out` with `coef_valid` high in cycle t+3. Positions appear in issue order, one per cycle.
- R6: At positions with row ≥ K or column ≥ K, `coef_out` is 0 while `coef_valid` is high. Whenever `coef_valid` is low, `coef_out` is 0.
- R7: `pix_valid` rises exactly LAT (default 93) cycles after the first cycle in which `coef_valid` is high. It then stays high for 64 × `num_blocks` consecutive cycles. `pix_out` equals `recon_pix` while `pix_valid` is high and is 0 otherwise.
- R8: `mem_we` is low in every cycle, including throughout a read.
- R9: `comp_lvl`, `start_addr` and `num_blocks` are sampled only at the accepting edge. Changing them during a read alters neither the address sequence, the enables, the coefficients nor the gate window of that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, sampled at each edge |
| start_addr | input | 19 | First memory address of the stored image |
| comp_lvl | input | 4 | Kept square size K (clamped) |
| num_blocks | input | 16 | Number of 8x8 blocks in the image |
| mem_addr | output | 19 | SRAM address |
| mem_cen | output | 1 | SRAM read enable, active high |
| mem_we | output | 1 | SRAM write enable, always low |
| mem_rdata | input | 12 | SRAM read data, two cycles after address |
| coef_out | output | 12 | Rebuilt coefficient stream to the inverse transform |
| coef_valid | output | 1 | Coefficient stream valid |
| recon_pix | input | 8 | Reconstructed pixel from the inverse transform |
| pix_out | output | 8 | Gated reconstructed pixel |
| pix_valid | output | 1 | Pixel forwarding window |
| read_frame | output | 1 | Read in progress; block owns the SRAM |

## Verification
The expansion is exercised with K of 5 over two blocks, K of 8 (a dense, contiguous address run), K of 1 (a single word per block), and the out-of-range codes 0 and 12. Together these show whether the row and column kept tests are applied separately, whether the clamp picks 8, and whether addresses carry across block boundaries. The SRAM model returns a distinctive filler word whenever no read was enabled. A zero-fill position that leaked memory data would show up as a nonzero coefficient, and a one-cycle alignment error would show up as a wrong value. A second request with different settings is made in the middle of a read to show that it and the new inputs are ignored. A request with a zero block count is made to show that it never starts a frame. The gate window is compared cycle by cycle against its 93-cycle offset for one-block and multi-block lengths.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int SIDE   = 8;
    localparam int SIDE_W = $clog2(SIDE);
    localparam int AREA_W = 2 * SIDE_W;
    localparam int LVL_W  = 4;

    function automatic logic [LVL_W-1:0] clamp_level(input logic [LVL_W-1:0] lvl);
        if (lvl == '0 || lvl > LVL_W'(SIDE))
            return LVL_W'(SIDE);
        return lvl;
    endfunction
endpackage

// File: rtl/trc_issue.sv
module trc_issue
    import trc_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [BLK_W-1:0]  nblk_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cen_o,
    output logic              pos_vld_o,
    output logic              pos_kept_o
);
    typedef struct packed {
        logic              on;
        logic [SIDE_W-1:0] row;
        logic [SIDE_W-1:0] col;
        logic [BLK_W-1:0]  blk;
        logic [BLK_W-1:0]  last;
        logic [LVL_W-1:0]  k;
        logic [ADDR_W-1:0] addr;
    } iss_t;

    iss_t iss_d, iss_q;
    logic kept;

    always_comb begin
        kept  = iss_q.on && ({1'b0, iss_q.row} < iss_q.k) && ({1'b0, iss_q.col} < iss_q.k);
        iss_d = iss_q;
        if (start_i) begin
            iss_d.on   = 1'b1;
            iss_d.row  = '0;
            iss_d.col  = '0;
            iss_d.blk  = '0;
            iss_d.last = nblk_i - 1'b1;
            iss_d.k    = clamp_level(lvl_i);
            iss_d.addr = start_addr_i;
        end else if (iss_q.on) begin
            if (kept)
                iss_d.addr = iss_q.addr + 1'b1;
            if (iss_q.col == SIDE_W'(SIDE - 1)) begin
                iss_d.col = '0;
                if (iss_q.row == SIDE_W'(SIDE - 1)) begin
                    iss_d.row = '0;
                    if (iss_q.blk == iss_q.last)
                        iss_d.on = 1'b0;
                    else
                        iss_d.blk = iss_q.blk + 1'b1;
                end else begin
                    iss_d.row = iss_q.row + 1'b1;
                end
            end else begin
                iss_d.col = iss_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign mem_addr_o = iss_q.addr;
    assign mem_cen_o  = kept;
    assign pos_vld_o  = iss_q.on;
    assign pos_kept_o = kept;

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cen_o ##1 mem_cen_o) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);

    // R2
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_q.on |-> (iss_q.k >= 1 && iss_q.k <= LVL_W'(SIDE)));
endmodule

// File: rtl/trc_fill.sv
module trc_fill #(
    parameter int COEF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pos_vld_i,
    input  logic              pos_kept_i,
    input  logic [COEF_W-1:0] mem_rdata_i,
    output logic [COEF_W-1:0] coef_o,
    output logic              coef_vld_o
);
    localparam int MEM_LAT = 2;

    typedef struct packed {
        logic [MEM_LAT-1:0] vld;
        logic [MEM_LAT-1:0] kept;
        logic [COEF_W-1:0]  coef;
        logic               cv;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        fill_d      = fill_q;
        fill_d.vld  = {fill_q.vld[MEM_LAT-2:0], pos_vld_i};
        fill_d.kept = {fill_q.kept[MEM_LAT-2:0], pos_kept_i};
        fill_d.cv   = fill_q.vld[MEM_LAT-1];
        fill_d.coef = (fill_q.vld[MEM_LAT-1] && fill_q.kept[MEM_LAT-1]) ? mem_rdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    assign coef_o     = fill_q.coef;
    assign coef_vld_o = fill_q.cv;

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_vld_o |-> coef_o == '0);

    // R5
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coef_vld_o) |-> $past(pos_vld_i, 3));
endmodule

// File: rtl/trc_gate.sv
module trc_gate
    import trc_pkg::*;
#(
    parameter int BLK_W = 16,
    parameter int PIX_W = 8,
    parameter int LAT   = 93
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] nblk_i,
    input  logic             coef_vld_i,
    input  logic [PIX_W-1:0] recon_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             pix_vld_o,
    output logic             done_o
);
    localparam int TMR_W = $clog2(LAT + 1);
    localparam int TOT_W = BLK_W + AREA_W;

    typedef struct packed {
        logic             armed;
        logic             timing;
        logic             fwd;
        logic [TMR_W-1:0] tmr;
        logic [TOT_W-1:0] cnt;
        logic [TOT_W-1:0] total;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        done_o = gate_q.fwd && (gate_q.cnt == gate_q.total - 1'b1);
        if (start_i) begin
            gate_d.armed = 1'b1;
            gate_d.total = {nblk_i, {AREA_W{1'b0}}};
        end else if (gate_q.armed && coef_vld_i) begin
            gate_d.armed  = 1'b0;
            gate_d.timing = 1'b1;
            gate_d.tmr    = TMR_W'(1);
        end
        if (gate_q.timing) begin
            if (gate_q.tmr == TMR_W'(LAT - 1)) begin
                gate_d.timing = 1'b0;
                gate_d.fwd    = 1'b1;
                gate_d.cnt    = '0;
            end else begin
                gate_d.tmr = gate_q.tmr + 1'b1;
            end
        end
        if (gate_q.fwd) begin
            gate_d.cnt = gate_q.cnt + 1'b1;
            if (done_o)
                gate_d.fwd = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign pix_vld_o = gate_q.fwd;
    assign pix_o     = gate_q.fwd ? recon_i : '0;

    // R7
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_vld_o) |-> $past(gate_q.tmr) == TMR_W'(LAT - 1));

    // R7
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld_o |-> pix_o == '0);
endmodule

// File: rtl/trc_reader.sv
module trc_reader
    import trc_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int COEF_W = 12,
    parameter int BLK_W  = 16,
    parameter int PIX_W  = 8,
    parameter int LAT    = 93
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LVL_W-1:0]  comp_lvl,
    input  logic [BLK_W-1:0]  num_blocks,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cen,
    output logic              mem_we,
    input  logic [COEF_W-1:0] mem_rdata,
    output logic [COEF_W-1:0] coef_out,
    output logic              coef_valid,
    input  logic [PIX_W-1:0]  recon_pix,
    output logic [PIX_W-1:0]  pix_out,
    output logic              pix_valid,
    output logic              read_frame
);
    logic frame_d, frame_q;
    logic accept;
    logic done;
    logic pos_vld, pos_kept;

    always_comb begin
        accept  = rd_req && !frame_q && (num_blocks != '0);
        frame_d = frame_q;
        if (accept)    frame_d = 1'b1;
        else if (done) frame_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b0;
        else        frame_q <= frame_d;
    end

    assign read_frame = frame_q;
    assign mem_we     = 1'b0;

    trc_issue #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) i_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept),
        .start_addr_i (start_addr),
        .lvl_i        (comp_lvl),
        .nblk_i       (num_blocks),
        .mem_addr_o   (mem_addr),
        .mem_cen_o    (mem_cen),
        .pos_vld_o    (pos_vld),
        .pos_kept_o   (pos_kept)
    );

    trc_fill #(.COEF_W(COEF_W)) i_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_vld_i   (pos_vld),
        .pos_kept_i  (pos_kept),
        .mem_rdata_i (mem_rdata),
        .coef_o      (coef_out),
        .coef_vld_o  (coef_valid)
    );

    trc_gate #(.BLK_W(BLK_W), .PIX_W(PIX_W), .LAT(LAT)) i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .nblk_i     (num_blocks),
        .coef_vld_i (coef_valid),
        .recon_i    (recon_pix),
        .pix_o      (pix_out),
        .pix_vld_o  (pix_valid),
        .done_o     (done)
    );

    // R3
    cen_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cen |-> read_frame);

    // R7
    gate_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> read_frame);

    // R1
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_frame) |-> $past(pix_valid));
endmodule

// File: tb/test_trc_reader.sv
module test_trc_reader;
    localparam int LAT = 93;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [18:0] start_addr = '0;
    logic [3:0]  comp_lvl = '0;
    logic [15:0] num_blocks = '0;
    logic [18:0] mem_addr;
    logic        mem_cen, mem_we;
    logic [11:0] mem_rdata = '0;
    logic [11:0] coef_out;
    logic        coef_valid;
    logic [7:0]  recon_pix = '0;
    logic [7:0]  pix_out;
    logic        pix_valid, read_frame;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    trc_reader i_trc_reader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .start_addr(start_addr),
        .comp_lvl(comp_lvl), .num_blocks(num_blocks), .mem_addr(mem_addr),
        .mem_cen(mem_cen), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .coef_out(coef_out), .coef_valid(coef_valid), .recon_pix(recon_pix),
        .pix_out(pix_out), .pix_valid(pix_valid), .read_frame(read_frame)
    );

    always #10 clk = ~clk;

    function automatic logic [11:0] memf(input int a);
        return 12'((a & 19'h7FFFF) * 53 + 7);
    endfunction

    // SRAM model: two-cycle read latency, filler word when not enabled
    logic [11:0] d1 = '0;
    always @(posedge clk) begin
        d1        <= mem_cen ? memf(int'(mem_addr)) : 12'hEEE;
        mem_rdata <= d1;
        recon_pix <= 8'(cyc) ^ 8'h5A;
        cyc       <= cyc + 1;
    end

    // reference model state
    bit m_busy = 0;
    int m_rel = 0;
    int m_k = 8;
    int m_start = 0;
    int m_total = 0;

    always @(posedge clk) begin
        bit was_busy;
        was_busy = m_busy;
        if (!rst_n) begin
            m_busy = 0;
        end else begin
            if (m_busy) begin
                m_rel = m_rel + 1;
                if (m_rel == 4 + LAT + m_total) m_busy = 0;
            end
            if (!was_busy && rd_req && num_blocks != 0) begin
                m_busy  = 1;
                m_rel   = 1;
                m_k     = (comp_lvl >= 1 && comp_lvl <= 8) ? int'(comp_lvl) : 8;
                m_start = int'(start_addr);
                m_total = 64 * int'(num_blocks);
            end
        end
    end

    function automatic bit kept_at(input int p, input int k);
        int w = p % 64;
        return (w / 8 < k) && (w % 8 < k);
    endfunction

    function automatic int kept_before(input int p, input int k);
        int b = p / 64;
        int w = p % 64;
        int r = w / 8;
        int c = w % 8;
        int inb = (r < k) ? r * k + ((c < k) ? c : k) : k * k;
        return b * k * k + inb;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int p, q, g;
            bit e_cen, e_cv, e_pv;
            int e_coef, e_addr;
            p = m_rel - 1;
            q = m_rel - 4;
            g = m_rel - 4 - LAT;
            e_cen  = m_busy && p >= 0 && p < m_total && kept_at(p, m_k);
            e_cv   = m_busy && q >= 0 && q < m_total;
            e_pv   = m_busy && g >= 0 && g < m_total;
            e_coef = (e_cv && kept_at(q, m_k)) ? int'(memf(m_start + kept_before(q, m_k))) : 0;
            e_addr = (m_start + kept_before(p, m_k)) & 32'h7FFFF;
            chk(read_frame == m_busy, "R1 read_frame", int'(read_frame), int'(m_busy));
            chk(mem_cen == e_cen, "R3 mem_cen", int'(mem_cen), int'(e_cen));
            if (e_cen) chk(int'(mem_addr) == e_addr, "R4 mem_addr", int'(mem_addr), e_addr);
            chk(coef_valid == e_cv, "R5 coef_valid", int'(coef_valid), int'(e_cv));
            chk(int'(coef_out) == e_coef, "R6 coef_out", int'(coef_out), e_coef);
            chk(pix_valid == e_pv, "R7 pix_valid", int'(pix_valid), int'(e_pv));
            chk(pix_out == (e_pv ? recon_pix : 8'd0), "R7 pix_out", int'(pix_out),
                e_pv ? int'(recon_pix) : 0);
            chk(mem_we == 1'b0, "R8 mem_we", int'(mem_we), 0);
        end
    end

    task automatic run(input int lvl, input int addr, input int nb, input bit disturb);
        @(negedge clk); #1;
        rd_req = 1; comp_lvl = 4'(lvl); start_addr = 19'(addr); num_blocks = 16'(nb);
        @(negedge clk); #1;
        rd_req = 0;
        if (disturb) begin
            // R9 and R1: new settings and a second request mid-read are ignored
            repeat (5) @(negedge clk);
            #1;
            rd_req = 1; comp_lvl = 4'd2; start_addr = 19'(addr + 100); num_blocks = 16'd1;
            @(negedge clk); #1;
            rd_req = 0;
            repeat (150) @(negedge clk);
            #1;
            rd_req = 1; comp_lvl = 4'd7;
            @(negedge clk); #1;
            rd_req = 0;
        end
        repeat (3) @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1;
        repeat (3) @(negedge clk);           // R1 reset/idle state checked each cycle
        run(5, 40, 2, 0);                    // R3 R4 R6 kept 5x5 over two blocks
        run(8, 19'h7FFF0, 1, 0);             // R4 dense run wrapping the address space
        run(1, 300, 3, 0);                   // R6 one word per block
        run(0, 1000, 1, 0);                  // R2 code 0 clamps to 8
        run(12, 2000, 2, 0);                 // R2 code 12 clamps to 8
        run(3, 500, 2, 1);                   // R9 disturbance during read
        run(6, 700, 0, 0);                   // R1 zero block count ignored
        run(7, 800, 4, 0);                   // R7 long gate window
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule